// File: doc/BRIEF.md
# E1 Transmit Frame Sync Controller

This block keeps the transmit bit and frame position of one E1 channel and sets where each frame and each CRC multiframe starts. A frame is 32 timeslots of 8 bits, so 256 bit periods. A multiframe is 16 frames. All state moves only on cycles where the serial clock enable is high. The bit position counts 0 to 255, and the frame number counts 0 to 15.

A two-bit timing-source code and a direction bit decide who owns the frame boundaries.

- **Block drives the boundaries (output mode):** the block raises a one-cycle frame pulse at bit 0 of every frame, and a multiframe pulse at bit 0 of frame 0.
- **System side drives the boundaries (input mode):** the block samples the frame and multiframe inputs, and either one realigns the counters.

A separate two-bit code is decoded into a one-hot selector. It tells the downstream inserter where the data-link bits come from: the serial payload, the HDLC controller, or the overhead port.

Top module: `e1_tx_sync_ctrl`

## Requirements
- R1: With timing-source code 2'b01 (serial input clock), direction bit 0 selects input mode (fs_oe=0, mfs_oe=0) and direction bit 1 selects output mode (fs_oe=1, mfs_oe=1).
- R2: With timing-source codes 2'b00, 2'b10 and 2'b11, the direction bit is inverted: 0 selects output mode and 1 selects input mode.
- R3: In output mode, fs_out is high exactly on enabled cycles where bit_pos is 0.
- R4: In output mode, mfs_out is high exactly on enabled cycles where bit_pos is 0 and frame_num is 0.
- R5: On each enabled cycle without realignment, bit_pos advances by one. From 255 it returns to 0 and frame_num advances by one, and frame_num returns from 15 to 0.
- R6: In input mode, fs_in high (with mfs_in low) on an enabled cycle makes bit_pos 0 on the next cycle and leaves frame_num unchanged.
- R7: In input mode, mfs_in high on an enabled cycle makes both bit_pos and frame_num 0 on the next cycle, whatever fs_in is.
- R8: In output mode, fs_in and mfs_in have no effect on bit_pos or frame_num.
- R9: On a cycle with ser_en low, bit_pos and frame_num hold, and fs_out and mfs_out are 0.
- R10: dl_src_sel is one-hot: bit 0 (serial payload) for codes 2'b00 and 2'b11, bit 1 (HDLC controller) for 2'b01, and bit 2 (overhead port) for 2'b10.
- R11: A synchronous reset sets bit_pos and frame_num to 0 on the next cycle, whether or not ser_en is high.
- R12: In input mode, fs_out and mfs_out stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Serial clock enable, one per transmit bit |
| clk_src | input | 2 | Timing-source code (01 serial, 10 internal, 00/11 recovered) |
| sync_dir | input | 1 | Sync direction configuration bit |
| fs_in | input | 1 | External frame sync |
| mfs_in | input | 1 | External multiframe sync |
| dl_code | input | 2 | Data-link source code |
| fs_out | output | 1 | Generated frame sync pulse |
| mfs_out | output | 1 | Generated multiframe sync pulse |
| fs_oe | output | 1 | Frame sync pin driven by the block |
| mfs_oe | output | 1 | Multiframe sync pin driven by the block |
| bit_pos | output | 8 | Bit position within the frame |
| frame_num | output | 4 | Frame number within the multiframe |
| dl_src_sel | output | 3 | One-hot data-link source selector |

## Verification
The bench runs in output mode through more than a full multiframe, with a continuous enable and then a gapped enable. It also drives spurious external pulses in output mode. These runs separate wrap handling, enable gating and the ignoring of the inputs. In input mode it applies frame pulses alone, multiframe pulses alone and both together, under both meanings of the direction bit. This separates a bit-only realignment from a full one, and checks which of the two wins. It also walks every combination of timing source, direction bit and data-link code, and applies a reset while the enable is low.

// File: rtl/e1s_pkg.sv
package e1s_pkg;

   typedef enum logic [1:0] {
      CS_RECOV_A  = 2'b00,
      CS_SERIAL   = 2'b01,
      CS_INTERNAL = 2'b10,
      CS_RECOV_B  = 2'b11
   } clk_src_e;

   typedef enum logic [1:0] {
      DL_PAYLOAD     = 2'b00,
      DL_HDLC        = 2'b01,
      DL_OVERHEAD    = 2'b10,
      DL_PAYLOAD_ALT = 2'b11
   } dl_src_e;

   localparam int DL_WAYS      = 3;
   localparam int DL_IDX_PAY   = 0;
   localparam int DL_IDX_HDLC  = 1;
   localparam int DL_IDX_OVH   = 2;

endpackage

// File: rtl/e1s_dir_resolve.sv
module e1s_dir_resolve
   import e1s_pkg::*;
(
   input  clk_src_e clk_src,
   input  logic     sync_dir,
   output logic     drive_sync
);

   always_comb begin
      if (clk_src == CS_SERIAL) drive_sync = sync_dir;
      else                      drive_sync = ~sync_dir;
   end

endmodule

// File: rtl/e1s_dl_decode.sv
module e1s_dl_decode
   import e1s_pkg::*;
(
   input  dl_src_e              code,
   output logic [DL_WAYS-1:0]   sel
);

   always_comb begin
      sel = '0;
      unique case (code)
         DL_HDLC:     sel[DL_IDX_HDLC] = 1'b1;
         DL_OVERHEAD: sel[DL_IDX_OVH]  = 1'b1;
         default:     sel[DL_IDX_PAY]  = 1'b1;
      endcase
   end

endmodule

// File: rtl/e1s_position_counter.sv
module e1s_position_counter #(
   parameter int BITS_PER_FRAME = 256,
   parameter int FRAMES_PER_MF  = 16,
   localparam int BW = $clog2(BITS_PER_FRAME),
   localparam int FW = $clog2(FRAMES_PER_MF)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          step_en,
   input  logic          realign_bit,
   input  logic          realign_mf,
   output logic [BW-1:0] bit_pos,
   output logic [FW-1:0] frame_num
);

   logic bit_last;
   logic frame_last;

   generate
      if (BITS_PER_FRAME < 2) begin : g_bad_bits
         $error("BITS_PER_FRAME must be at least 2");
      end
      if (FRAMES_PER_MF < 2) begin : g_bad_frames
         $error("FRAMES_PER_MF must be at least 2");
      end

      if ((1 << BW) == BITS_PER_FRAME) begin : g_bit_pow2
         assign bit_last = &bit_pos;
      end else begin : g_bit_cmp
         assign bit_last = (bit_pos == BW'(BITS_PER_FRAME - 1));
      end

      if ((1 << FW) == FRAMES_PER_MF) begin : g_frm_pow2
         assign frame_last = &frame_num;
      end else begin : g_frm_cmp
         assign frame_last = (frame_num == FW'(FRAMES_PER_MF - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_pos   <= '0;
         frame_num <= '0;
      end else if (step_en) begin
         if (realign_mf) begin
            bit_pos   <= '0;
            frame_num <= '0;
         end else if (realign_bit) begin
            bit_pos   <= '0;
         end else if (bit_last) begin
            bit_pos   <= '0;
            frame_num <= frame_last ? '0 : frame_num + 1'b1;
         end else begin
            bit_pos   <= bit_pos + 1'b1;
         end
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> ($stable(bit_pos) && $stable(frame_num)));                 // R9
   AST_EXT_FRAME: assert property (@(posedge clk) disable iff (rst)
      (step_en && realign_bit && !realign_mf) |=>
         (bit_pos == '0 && frame_num == $past(frame_num)));                   // R6
   AST_EXT_MF: assert property (@(posedge clk) disable iff (rst)
      (step_en && realign_mf) |=> (bit_pos == '0 && frame_num == '0));        // R7
   AST_WRAP_ADV: assert property (@(posedge clk) disable iff (rst)
      (step_en && !realign_bit && !realign_mf && bit_pos == BW'(BITS_PER_FRAME - 1)
       && frame_num != FW'(FRAMES_PER_MF - 1)) |=>
         (bit_pos == '0 && frame_num == $past(frame_num) + 1'b1));            // R5

endmodule

// File: rtl/e1_tx_sync_ctrl.sv
module e1_tx_sync_ctrl
   import e1s_pkg::*;
#(
   parameter int SLOTS_PER_FRAME = 32,
   parameter int BITS_PER_SLOT   = 8,
   parameter int FRAMES_PER_MF   = 16,
   localparam int BITS_PER_FRAME = SLOTS_PER_FRAME * BITS_PER_SLOT,
   localparam int BW = $clog2(BITS_PER_FRAME),
   localparam int FW = $clog2(FRAMES_PER_MF)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          ser_en,
   input  logic [1:0]    clk_src,
   input  logic          sync_dir,
   input  logic          fs_in,
   input  logic          mfs_in,
   input  logic [1:0]    dl_code,
   output logic          fs_out,
   output logic          mfs_out,
   output logic          fs_oe,
   output logic          mfs_oe,
   output logic [BW-1:0] bit_pos,
   output logic [FW-1:0] frame_num,
   output logic [2:0]    dl_src_sel
);

   logic drive_sync;
   logic at_frame_start;
   logic at_mf_start;
   logic ext_fs;
   logic ext_mfs;

   generate
      if (SLOTS_PER_FRAME < 1 || BITS_PER_SLOT < 1) begin : g_bad_geom
         $error("frame geometry parameters must be positive");
      end
      if (DL_WAYS != 3) begin : g_bad_dl
         $error("data-link selector port expects three sources");
      end
   endgenerate

   e1s_dir_resolve u_dir (
      .clk_src    (clk_src_e'(clk_src)),
      .sync_dir   (sync_dir),
      .drive_sync (drive_sync)
   );

   assign ext_fs  = ~drive_sync & fs_in;
   assign ext_mfs = ~drive_sync & mfs_in;

   e1s_position_counter #(
      .BITS_PER_FRAME (BITS_PER_FRAME),
      .FRAMES_PER_MF  (FRAMES_PER_MF)
   ) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .step_en     (ser_en),
      .realign_bit (ext_fs),
      .realign_mf  (ext_mfs),
      .bit_pos     (bit_pos),
      .frame_num   (frame_num)
   );

   e1s_dl_decode u_dl (
      .code (dl_src_e'(dl_code)),
      .sel  (dl_src_sel)
   );

   assign at_frame_start = (bit_pos == '0);
   assign at_mf_start    = at_frame_start & (frame_num == '0);

   assign fs_oe   = drive_sync;
   assign mfs_oe  = drive_sync;
   assign fs_out  = drive_sync & ser_en & at_frame_start;
   assign mfs_out = drive_sync & ser_en & at_mf_start;

   AST_SERIAL_DIR: assert property (@(posedge clk) disable iff (rst)
      (clk_src == 2'b01) |-> (fs_oe == sync_dir && mfs_oe == sync_dir));      // R1
   AST_OTHER_DIR: assert property (@(posedge clk) disable iff (rst)
      (clk_src != 2'b01) |-> (fs_oe != sync_dir && mfs_oe != sync_dir));      // R2
   AST_FS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
      fs_out |-> (bit_pos == '0 && ser_en));                                  // R3
   AST_MF_IN_FS: assert property (@(posedge clk) disable iff (rst)
      mfs_out |-> (fs_out && frame_num == '0));                               // R4
   AST_OUT_IGNORES: assert property (@(posedge clk) disable iff (rst)
      (ser_en && fs_oe && bit_pos != BW'(BITS_PER_FRAME - 1)) |=>
         (bit_pos == $past(bit_pos) + 1'b1));                                 // R8
   AST_DL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(dl_src_sel) == 1);                                           // R10
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (bit_pos == '0 && frame_num == '0));                            // R11
   AST_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
      !fs_oe |-> (!fs_out && !mfs_out));                                      // R12

endmodule

// File: tb/sim_e1_tx_sync_ctrl.sv
`timescale 1ns/1ps
module sim_e1_tx_sync_ctrl;

   logic       clk = 1'b0;
   logic       rst, ser_en, sync_dir, fs_in, mfs_in;
   logic [1:0] clk_src, dl_code;
   logic       fs_out, mfs_out, fs_oe, mfs_oe;
   logic [7:0] bit_pos;
   logic [3:0] frame_num;
   logic [2:0] dl_src_sel;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   int    m_bit = 0;
   int    m_frame = 0;
   string last_tag = "R11";

   always #4 clk = ~clk;

   e1_tx_sync_ctrl u0 (
      .clk(clk), .rst(rst), .ser_en(ser_en), .clk_src(clk_src), .sync_dir(sync_dir),
      .fs_in(fs_in), .mfs_in(mfs_in), .dl_code(dl_code), .fs_out(fs_out),
      .mfs_out(mfs_out), .fs_oe(fs_oe), .mfs_oe(mfs_oe), .bit_pos(bit_pos),
      .frame_num(frame_num), .dl_src_sel(dl_src_sel)
   );

   function automatic bit model_out_mode();
      return (clk_src == 2'b01) ? sync_dir : !sync_dir;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit om = model_out_mode();
      int exp_fs  = (om && ser_en && m_bit == 0) ? 1 : 0;
      int exp_mfs = (exp_fs == 1 && m_frame == 0) ? 1 : 0;
      int exp_dl  = (dl_code == 2'b01) ? 2 : (dl_code == 2'b10) ? 4 : 1;
      string dir_req = (clk_src == 2'b01) ? "R1" : "R2";
      string out_req = !om ? "R12" : (!ser_en ? "R9" : "R3");
      chk(dir_req, "fs_oe", fs_oe, om);
      chk(dir_req, "mfs_oe", mfs_oe, om);
      chk(out_req, "fs_out", fs_out, exp_fs);
      chk((out_req == "R3") ? "R4" : out_req, "mfs_out", mfs_out, exp_mfs);
      chk(last_tag, "bit_pos", bit_pos, m_bit);
      chk(last_tag, "frame_num", frame_num, m_frame);
      chk("R10", "dl_src_sel", dl_src_sel, exp_dl);
   endtask

   task automatic update_model();
      bit om = model_out_mode();
      if (rst) begin
         m_bit = 0; m_frame = 0; last_tag = "R11";
      end else if (!ser_en) begin
         last_tag = "R9";
      end else if (!om && mfs_in) begin
         m_bit = 0; m_frame = 0; last_tag = "R7";
      end else if (!om && fs_in) begin
         m_bit = 0; last_tag = "R6";
      end else begin
         last_tag = (om && (fs_in || mfs_in)) ? "R8" : "R5";
         if (m_bit == 255) begin
            m_bit = 0;
            m_frame = (m_frame + 1) % 16;
         end else m_bit++;
      end
   endtask

   task automatic step(input bit r, input bit en, input bit [1:0] cs, input bit dir,
                       input bit fs, input bit mfs, input bit [1:0] dl);
      @(negedge clk);
      rst = r; ser_en = en; clk_src = cs; sync_dir = dir;
      fs_in = fs; mfs_in = mfs; dl_code = dl;
      #1;
      if (!done) compare();
      @(posedge clk);
      update_model();
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      rst = 1; ser_en = 1; clk_src = 2'b01; sync_dir = 1;
      fs_in = 0; mfs_in = 0; dl_code = 2'b00;
      // R11 reset state
      for (int i = 0; i < 3; i++) step(1, 1, 2'b01, 1, 0, 0, 2'b00);
      // R3 R4 R5 R8: output mode over more than one multiframe, spurious inputs
      for (int i = 0; i < 4400; i++)
         step(0, 1, 2'b01, 1, (i % 37) == 5, (i % 53) == 7, 2'(i / 1000));
      // R9: gapped enable in output mode (internal clock, dir 0)
      for (int i = 0; i < 700; i++) step(0, (i % 3) != 0, 2'b10, 0, 0, 0, 2'b01);
      // R6 R7 R12: input mode, serial clock, dir 0
      for (int i = 0; i < 1500; i++)
         step(0, 1, 2'b01, 0, (i % 100) == 40, (i % 700) == 333, 2'b10);
      // R7: both syncs together, recovered clock, dir 1 (input)
      for (int i = 0; i < 600; i++)
         step(0, (i % 5) != 2, 2'b11, 1, (i % 90) == 10, (i % 90) == 10, 2'b11);
      // R6 with enable low: pulse ignored when not enabled
      for (int i = 0; i < 300; i++)
         step(0, (i % 2) == 0, 2'b00, 1, (i % 7) == 1, 0, 2'b00);
      // R1 R2 R10: every source/direction/data-link combination
      for (int c = 0; c < 4; c++)
         for (int d = 0; d < 2; d++)
            for (int k = 0; k < 4; k++)
               step(0, 1, 2'(c), d[0], 0, 0, 2'(k));
      // R11: reset with enable low mid-count
      for (int i = 0; i < 40; i++) step(0, 1, 2'b10, 0, 0, 0, 2'b00);
      for (int i = 0; i < 2; i++) step(1, 0, 2'b10, 0, 0, 0, 2'b00);
      for (int i = 0; i < 20; i++) step(0, 1, 2'b10, 0, 0, 0, 2'b00);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule